// File: doc/BRIEF.md
# Four-Bank DRAM Strobe and Refresh Controller

This block drives the row and column strobes of four 64 KiB dynamic RAM banks that together fill the bottom 256 KiB of a 1 MiB byte address space. When a processor memory read or write falls inside that region, address bits 17:16 choose the bank. The remaining 16 bits are sent over an 8-bit multiplexed address bus, row byte first and column byte second. The selected bank's RAS then CAS strobe is pulled low. While CAS is low, the DRAM data word is nine bits wide: eight data bits plus one parity bit. The parity bit is generated on writes and checked on reads.

A free-running interval timer raises a refresh request toward a DMA channel. When that channel's acknowledge rises, the controller runs a RAS-only refresh of the current refresh row on all four banks at the same time, then advances the row counter. The memory arrays are not part of the block.

Top module: `dram_bank_ctl`

## Requirements
- R1: For an in-range command, bank = addr[17:16]. Only that bank's `ras_n`/`cas_n` bit (bit index = bank) goes low, with active-low strobes.
- R2: A read or write command with addr[19:18] not equal to zero produces no RAS or CAS strobe.
- R3: With no command and no refresh in progress, all RAS and CAS lines and `we_n` stay high, including the reset state. `refresh_req` and `par_err` are low after reset.
- R4: The access runs in clock-long phases. The clock edge that samples the command enters the row phase (address set up, strobes high). Each following edge enters, in turn: RAS low, column on the bus with RAS still low, and CAS low. CAS is held until the command drops. One clock with all strobes high follows before the controller returns to idle.
- R5: In the row phase and the RAS phase, `ma` carries addr[15:8]. In the column phase and the CAS phase, `ma` carries addr[7:0].
- R6: In a write, `we_n` is low during the column and CAS phases. `md_out` is {parity, wdata}, with the parity bit in bit 8 chosen so that the nine bits hold an odd number of ones.
- R7: In a read, the edge on which the command is seen low during the CAS phase loads `rdata` with `md_in[7:0]`. `rdata` holds that value afterwards.
- R8: On the same edge as R7, `par_err` rises for exactly one clock if the nine bits of `md_in` hold an even number of ones. Otherwise it stays low.
- R9: A rising `refresh_dack` starts a refresh. The first clock has all strobes high with the refresh row on `ma`. The next clock has all four RAS low and every CAS high. The clock after that releases all strobes. The refresh row starts at 0 after reset and increments by one per refresh.
- R10: `refresh_req` rises once every REFRESH_PERIOD clocks. It stays high until `refresh_dack` is seen and is then cleared on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | input | 1 | Memory read command, held for the access |
| mem_wr | input | 1 | Memory write command, held for the access |
| addr | input | 20 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| par_err | output | 1 | One-clock read parity error pulse |
| ma | output | 8 | Multiplexed row/column address |
| ras_n | output | 4 | Row strobes, one per bank, active low |
| cas_n | output | 4 | Column strobes, one per bank, active low |
| we_n | output | 1 | DRAM write enable, active low |
| md_out | output | 9 | Data plus parity toward the DRAM |
| md_in | input | 9 | Data plus parity from the DRAM |
| refresh_req | output | 1 | Periodic refresh request |
| refresh_dack | input | 1 | Refresh DMA acknowledge |

## Verification
The command sampled at an edge shows its row phase after that same edge. RAS, column and CAS each follow one edge later. Read data and the parity pulse appear one edge after the command is dropped in the CAS phase. A refresh shows its row one edge after the acknowledge rises, with all RAS low on the following edge. The bench drives every input on the falling edge and samples on the next falling edge, walking these phases one edge at a time. It measures the refresh request interval in whole clocks between two genuine rising edges of the request.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_RAS, ST_COL, ST_CAS, ST_PRE,
    ST_RROW, ST_RRAS, ST_RPRE
  } seq_state_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int PERIOD = 3780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic req
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             wrap;

  assign wrap = (cnt_q == '0);

  always_comb begin
    cnt_d = wrap ? CNT_W'(PERIOD - 1) : cnt_q - 1'b1;
    req_d = req_q;
    if (ack)  req_d = 1'b0;
    if (wrap) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(PERIOD - 1);
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/dram_parity.sv
module dram_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W:0]   wr_word,
  input  logic [DATA_W:0]   rd_word,
  output logic              rd_ok
);
  // odd parity over the stored nine-bit word
  assign wr_word = {~^wr_data, wr_data};
  assign rd_ok   = ^rd_word;
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int MA_W   = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              cmd_wr,
  input  logic              cmd_active,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [MA_W-1:0]   row_in,
  input  logic [MA_W-1:0]   col_in,
  input  logic              ref_dack,
  output logic              accept,
  output logic              rd_done,
  output logic [MA_W-1:0]   ma,
  output logic [BANKS-1:0]  ras_n,
  output logic [BANKS-1:0]  cas_n,
  output logic              we_n
);
  seq_state_e        state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic [MA_W-1:0]   row_q, col_q, ref_row_q;
  logic              wr_q, dack_q, pend_q, pend_d;
  logic              dack_rise, start_ref, row_inc;
  logic [BANKS-1:0]  bank_sel;

  assign dack_rise = ref_dack & ~dack_q;
  assign start_ref = (state_q == ST_IDLE) & (pend_q | dack_rise);
  assign accept    = (state_q == ST_IDLE) & ~(pend_q | dack_rise) & cmd_go;
  assign pend_d    = (pend_q | dack_rise) & (state_q != ST_IDLE);
  assign row_inc   = (state_q == ST_RRAS);
  assign rd_done   = (state_q == ST_CAS) & ~cmd_active & ~wr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_ref) state_d = ST_RROW;
               else if (cmd_go) state_d = ST_ROW;
      ST_ROW:  state_d = ST_RAS;
      ST_RAS:  state_d = ST_COL;
      ST_COL:  state_d = ST_CAS;
      ST_CAS:  if (!cmd_active) state_d = ST_PRE;
      ST_PRE:  state_d = ST_IDLE;
      ST_RROW: state_d = ST_RRAS;
      ST_RRAS: state_d = ST_RPRE;
      ST_RPRE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      dack_q    <= 1'b0;
      pend_q    <= 1'b0;
      ref_row_q <= '0;
    end else begin
      state_q <= state_d;
      dack_q  <= ref_dack;
      pend_q  <= pend_d;
      if (row_inc) ref_row_q <= ref_row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      bank_q <= bank_in;
      row_q  <= row_in;
      col_q  <= col_in;
      wr_q   <= cmd_wr;
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_sel
    assign bank_sel[g] = (bank_q == BANK_W'(g));
  end

  always_comb begin
    ma    = '0;
    ras_n = '1;
    cas_n = '1;
    we_n  = 1'b1;
    unique case (state_q)
      ST_ROW:  ma = row_q;
      ST_RAS:  begin ma = row_q; ras_n = ~bank_sel; end
      ST_COL:  begin ma = col_q; ras_n = ~bank_sel; we_n = ~wr_q; end
      ST_CAS:  begin ma = col_q; ras_n = ~bank_sel; cas_n = ~bank_sel; we_n = ~wr_q; end
      ST_RROW: ma = ref_row_q;
      ST_RRAS: begin ma = ref_row_q; ras_n = '0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/dram_bank_ctl.sv
module dram_bank_ctl #(
  parameter int ADDR_W         = 20,
  parameter int DATA_W         = 8,
  parameter int BANKS          = 4,
  parameter int MA_W           = 8,
  parameter int REFRESH_PERIOD = 3780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              par_err,
  output logic [MA_W-1:0]   ma,
  output logic [BANKS-1:0]  ras_n,
  output logic [BANKS-1:0]  cas_n,
  output logic              we_n,
  output logic [DATA_W:0]   md_out,
  input  logic [DATA_W:0]   md_in,
  output logic              refresh_req,
  input  logic              refresh_dack
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int IN_W   = 2 * MA_W;
  localparam int TOP_LO = IN_W + BANK_W;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              cmd_active, in_range, cmd_go, accept, rd_done, rd_ok;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              par_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign cmd_active = mem_rd | mem_wr;
  assign in_range   = (addr[ADDR_W-1:TOP_LO] == '0);
  assign cmd_go     = cmd_active & in_range;

  dram_seq #(.BANKS(BANKS), .MA_W(MA_W), .BANK_W(BANK_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .cmd_go(cmd_go), .cmd_wr(mem_wr), .cmd_active(cmd_active),
    .bank_in(addr[TOP_LO-1:IN_W]), .row_in(addr[IN_W-1:MA_W]),
    .col_in(addr[MA_W-1:0]), .ref_dack(refresh_dack),
    .accept(accept), .rd_done(rd_done),
    .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  dram_refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .ack(refresh_dack), .req(refresh_req)
  );

  dram_parity #(.DATA_W(DATA_W)) u_par (
    .wr_data(wdata_q), .wr_word(md_out), .rd_word(md_in), .rd_ok(rd_ok)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) wdata_q <= '0;
    else if (accept) wdata_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q   <= '0;
      par_err_q <= 1'b0;
    end else begin
      if (rd_done) rdata_q <= md_in[DATA_W-1:0];
      par_err_q <= rd_done & ~rd_ok;
    end
  end

  assign rdata   = rdata_q;
  assign par_err = par_err_q;
endmodule

// File: rtl/dram_bank_ctl_chk.sv
module dram_bank_ctl_chk #(
  parameter int BANKS = 4,
  parameter int MA_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BANKS-1:0] ras_n,
  input logic [BANKS-1:0] cas_n,
  input logic [MA_W-1:0]  ma,
  input logic             we_n,
  input logic             par_err
);
  // R1
  cas_single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cas_n));
  // R1
  ras_one_or_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ras_n) || (ras_n == '0));
  // R4
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cas_n) & ras_n) == '0);
  // R4
  cas_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cas_n != '1) && ($past(cas_n) == '1)) |-> ($past(ras_n) != '1));
  // R5
  row_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ras_n != '1) && ($past(ras_n) == '1)) |-> $stable(ma));
  // R5
  col_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cas_n != '1) && ($past(cas_n) == '1)) |-> $stable(ma));
  // R6
  we_inside_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (ras_n != '1));
  // R8
  par_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !par_err);
  // R9
  refresh_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0) |-> (cas_n == '1));
endmodule

bind dram_bank_ctl dram_bank_ctl_chk #(.BANKS(BANKS), .MA_W(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .ma(ma), .we_n(we_n), .par_err(par_err)
);

// File: tb/dram_bank_ctl_tb.sv
module dram_bank_ctl_tb;
  localparam int PER = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0, refresh_dack = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [8:0]  md_in = '0;
  logic [7:0]  rdata, ma;
  logic        par_err, we_n, refresh_req;
  logic [3:0]  ras_n, cas_n;
  logic [8:0]  md_out;

  int          n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0]  exp_row = 8'd0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dram_bank_ctl #(.REFRESH_PERIOD(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .par_err(par_err),
    .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .md_out(md_out), .md_in(md_in),
    .refresh_req(refresh_req), .refresh_dack(refresh_dack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  task automatic t_reset();
    check("R3 reset ras", 32'(ras_n), 32'hF);
    check("R3 reset cas", 32'(cas_n), 32'hF);
    check("R3 reset we_n", 32'(we_n), 32'h1);
    check("R3 reset refresh_req", 32'(refresh_req), 32'h0);
    check("R3 reset par_err", 32'(par_err), 32'h0);
  endtask

  task automatic t_write(input logic [19:0] a, input logic [7:0] d);
    logic [3:0] eb;
    eb = ~(4'b1 << a[17:16]);
    @(negedge clk); addr = a; wdata = d; mem_wr = 1'b1;
    @(negedge clk);
    check("R4 row phase strobes", 32'({ras_n, cas_n}), 32'hFF);
    check("R5 row address", 32'(ma), 32'(a[15:8]));
    @(negedge clk);
    check("R1 bank ras", 32'(ras_n), 32'(eb));
    check("R4 cas high in ras phase", 32'(cas_n), 32'hF);
    @(negedge clk);
    check("R5 column address", 32'(ma), 32'(a[7:0]));
    check("R4 ras held in column phase", 32'(ras_n), 32'(eb));
    check("R6 we_n low column", 32'(we_n), 32'h0);
    @(negedge clk);
    check("R1 bank cas", 32'(cas_n), 32'(eb));
    check("R6 we_n low cas", 32'(we_n), 32'h0);
    check("R6 md_out odd parity", 32'(md_out), 32'({~^d, d}));
    mem_wr = 1'b0;
    @(negedge clk);
    check("R4 precharge strobes", 32'({ras_n, cas_n, we_n}), 32'h1FF);
  endtask

  task automatic t_read(input logic [19:0] a, input logic [8:0] word);
    logic [3:0] eb;
    eb = ~(4'b1 << a[17:16]);
    @(negedge clk); addr = a; mem_rd = 1'b1; md_in = word;
    @(negedge clk);
    check("R5 read row address", 32'(ma), 32'(a[15:8]));
    @(negedge clk);
    check("R1 read ras", 32'(ras_n), 32'(eb));
    @(negedge clk);
    check("R6 we_n high on read", 32'(we_n), 32'h1);
    @(negedge clk);
    check("R1 read cas", 32'(cas_n), 32'(eb));
    mem_rd = 1'b0;
    @(negedge clk);
    check("R7 rdata", 32'(rdata), 32'(word[7:0]));
    check("R8 par_err", 32'(par_err), 32'(~^word));
    md_in = 9'h000;
    @(negedge clk);
    check("R8 par_err one clock", 32'(par_err), 32'h0);
    check("R7 rdata held", 32'(rdata), 32'(word[7:0]));
  endtask

  task automatic t_out_of_range(input logic [19:0] a);
    @(negedge clk); addr = a; mem_rd = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R2 no strobes out of range", 32'({ras_n, cas_n}), 32'hFF);
    end
    mem_rd = 1'b0;
  endtask

  task automatic t_refresh();
    @(negedge clk); refresh_dack = 1'b1;
    @(negedge clk);
    check("R9 refresh row phase strobes", 32'({ras_n, cas_n}), 32'hFF);
    check("R9 refresh row", 32'(ma), 32'(exp_row));
    refresh_dack = 1'b0;
    @(negedge clk);
    check("R9 all ras low", 32'(ras_n), 32'h0);
    check("R9 no cas in refresh", 32'(cas_n), 32'hF);
    @(negedge clk);
    check("R9 refresh release", 32'({ras_n, cas_n}), 32'hFF);
    exp_row++;
    @(negedge clk);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 4 * PER && !refresh_req; i++) @(negedge clk);
  endtask

  task automatic t_timer();
    int gap;
    wait_req();
    @(negedge clk); refresh_dack = 1'b1;
    @(negedge clk); refresh_dack = 1'b0;
    check("R10 request cleared by ack", 32'(refresh_req), 32'h0);
    exp_row++;
    wait_req();
    check("R10 request raised", 32'(refresh_req), 32'h1);
    @(negedge clk);
    check("R10 request held until ack", 32'(refresh_req), 32'h1);
    refresh_dack = 1'b1;
    gap = 1;
    @(negedge clk); refresh_dack = 1'b0; gap++;
    exp_row++;
    for (int i = 0; i < 4 * PER && !refresh_req; i++) begin
      @(negedge clk); gap++;
    end
    check("R10 request interval", 32'(gap), 32'(PER));
    @(negedge clk); refresh_dack = 1'b1;
    @(negedge clk); refresh_dack = 1'b0;
    exp_row++;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write(20'h0_1234, 8'h5A);
    t_write(20'h1_ABCD, 8'h01);
    t_write(20'h2_FF00, 8'hFF);
    t_write(20'h3_0001, 8'h80);
    t_read(20'h2_4321, {~^8'hC3, 8'hC3});
    t_read(20'h1_00FF, {^8'h7E, 8'h7E});
    t_read(20'h3_FFFF, {~^8'h00, 8'h00});
    t_out_of_range(20'h4_0000);
    t_out_of_range(20'hC_1234);
    t_refresh();
    t_refresh();
    t_timer();
    t_refresh();
    t_read(20'h0_0000, {^8'h11, 8'h11});
    done = 1'b1;
    summary();
    $finish;
  end
endmodule